// File: doc/BRIEF.md
# Serial Channel Interrupt Source Generator

This block forms the three interrupt request conditions of one serial channel: a receive request, a transmit request and an external/status request. It watches the receive FIFO fill level, the per-character receive error strobes, the transmit FIFO fill level, the host write strobe into the transmitter, and six external status lines. Configuration inputs choose the receive fill threshold, the transmit trigger point, whether parity errors count as special conditions, and which external sources are enabled.

Receive errors collect in a latched special-condition word that the host reads and then clears with an error-reset strobe. While any special condition is latched, it takes precedence over the ordinary data-available request. External sources are detected on either edge of their input. They stay latched until the host pulses a reset strobe. Every request is a registered level that follows its inputs one clock later.

Top module: `serial_irq_gen`

## Requirements
- R1: With `cfg_rx_quad` = 0, `rx_req` is 1 one cycle after `rx_count` is at least 1, and 0 one cycle after `rx_count` is 0, provided no special condition is latched.
- R2: With `cfg_rx_quad` = 1, `rx_req` is 1 one cycle after `rx_count` is at least 4, and 0 one cycle after a count of 3 or less.
- R3: A pulse on `rx_err_ovr`, `rx_err_crc` or `rx_err_eof` sets bit 0, 1 or 2 of `sc_status` one cycle later. The bit stays set until it is cleared.
- R4: A pulse on `rx_err_par` sets `sc_status` bit 3 only when `cfg_par_sc` = 1. Otherwise it leaves `sc_status` and `sc_req` unchanged.
- R5: `sc_req` is 1 exactly when `sc_status` is nonzero. While it is 1, `rx_req` is 0 whatever the fill level.
- R6: A pulse on `clr_sc` clears `sc_status` one cycle later. An error strobe in the same cycle as the clear is kept.
- R7: With `cfg_tx_entry` = 0, `tx_req` is 1 one cycle after `tx_count` is 0, and 0 one cycle after a nonzero count.
- R8: With `cfg_tx_entry` = 1, `tx_req` is 1 one cycle after `tx_count` is below 4 (at least one entry free), and 0 one cycle after a full count of 4.
- R9: After reset, `tx_req` stays 0 until the first `tx_wr` strobe, whatever the fill level and mode.
- R10: A rising or falling transition on `ext_in[i]` while `cfg_ext_en[i]` = 1 sets `ext_pend[i]` one cycle later, and `ext_req` is its OR. Transitions on disabled sources latch nothing. Bit order: 0 zero count, 1 carrier detect, 2 sync/hunt, 3 clear to send, 4 transmit underrun/end of message, 5 break/abort.
- R11: A pulse on `clr_ext` clears `ext_pend` one cycle later. An enabled transition in the same cycle as the clear is kept.
- R12: While `rst_n` is low, every request output, `sc_status` and `ext_pend` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rx_quad | input | 1 | Receive threshold: 0 one byte, 1 four bytes |
| cfg_tx_entry | input | 1 | Transmit trigger: 0 fully empty, 1 entry free |
| cfg_par_sc | input | 1 | Parity error counts as a special condition |
| cfg_ext_en | input | 6 | Per-source external/status enables |
| rx_count | input | 3 | Receive FIFO fill level |
| rx_err_ovr | input | 1 | Receive overrun strobe |
| rx_err_crc | input | 1 | CRC or framing error strobe |
| rx_err_eof | input | 1 | End-of-frame strobe |
| rx_err_par | input | 1 | Parity error strobe |
| clr_sc | input | 1 | Host error-reset strobe |
| tx_wr | input | 1 | Host wrote a character into the transmitter |
| tx_count | input | 3 | Transmit FIFO fill level |
| ext_in | input | 6 | External/status source levels |
| clr_ext | input | 1 | Host external/status reset strobe |
| rx_req | output | 1 | Receive data available request |
| sc_req | output | 1 | Receive special-condition request |
| sc_status | output | 4 | Latched special-condition word |
| tx_req | output | 1 | Transmit request |
| ext_req | output | 1 | External/status request |
| ext_pend | output | 6 | Latched external/status events |

## Verification
The assertions assume that all inputs are synchronous to `clk`, that the fill counts never exceed the FIFO depths, and that the configuration bits change only between cycles and never on a clock edge. The bench drives every input half a period away from the rising edge and uses only counts from 0 to 4. It also holds the external lines low through reset, so that the first sampled level is a true baseline. Error and clear strobes last exactly one cycle, so the edge-to-latch timing the properties expect is the timing the stimulus produces.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
    localparam int SC_W      = 4;
    localparam int SC_OVR    = 0;
    localparam int SC_CRC    = 1;
    localparam int SC_EOF    = 2;
    localparam int SC_PAR    = 3;
    localparam int EXT_N     = 6;
    localparam int EXT_ZC    = 0;
    localparam int EXT_DCD   = 1;
    localparam int EXT_SYNC  = 2;
    localparam int EXT_CTS   = 3;
    localparam int EXT_UNDR  = 4;
    localparam int EXT_BRK   = 5;
endpackage

// File: rtl/irq_rx_cond.sv
module irq_rx_cond
    import irq_src_pkg::*;
#(
    parameter int RX_DEPTH = 4,
    parameter int RX_QUAD_LVL = 4,
    localparam int CNT_W = $clog2(RX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_quad,
    input  logic             cfg_par_sc,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             err_ovr,
    input  logic             err_crc,
    input  logic             err_eof,
    input  logic             err_par,
    input  logic             clr_sc,
    output logic             rx_req,
    output logic             sc_req,
    output logic [SC_W-1:0]  sc_status
);
    typedef struct packed {
        logic            avail;
        logic [SC_W-1:0] status;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic [SC_W-1:0] new_err;

    always_comb begin
        st_d = st_q;
        new_err = '0;
        new_err[SC_OVR] = err_ovr;
        new_err[SC_CRC] = err_crc;
        new_err[SC_EOF] = err_eof;
        new_err[SC_PAR] = err_par & cfg_par_sc;
        if (cfg_quad) st_d.avail = (rx_count >= CNT_W'(RX_QUAD_LVL));
        else          st_d.avail = (rx_count != '0);
        st_d.status = (clr_sc ? '0 : st_q.status) | new_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sc_status = st_q.status;
    assign sc_req    = |st_q.status;
    assign rx_req    = st_q.avail & ~sc_req;

    assert_quad_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_quad && rx_count < CNT_W'(RX_QUAD_LVL)) |=> !rx_req);
    assert_single_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_quad && rx_count == '0) |=> !rx_req);
    assert_status_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_sc && !err_ovr && !err_crc && !err_eof && !err_par) |=> $stable(sc_status));
    assert_parity_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sc_status[SC_PAR]) |-> $past(cfg_par_sc));
    assert_precedence_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |-> !rx_req);
endmodule

// File: rtl/irq_tx_cond.sv
module irq_tx_cond #(
    parameter int TX_DEPTH = 4,
    localparam int TX_CNT_W = $clog2(TX_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_entry,
    input  logic                tx_wr,
    input  logic [TX_CNT_W-1:0] tx_count,
    output logic                tx_req
);
    typedef struct packed {
        logic armed;
        logic req;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic      trig;

    always_comb begin
        st_d = st_q;
        if (cfg_entry) trig = (tx_count < TX_CNT_W'(TX_DEPTH));
        else           trig = (tx_count == '0);
        st_d.armed = st_q.armed | tx_wr;
        st_d.req   = st_q.armed & trig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_req = st_q.req;

    assert_no_req_unarmed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> $past(st_q.armed));
    assert_empty_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_entry && tx_count != '0) |=> !tx_req);
    assert_entry_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_entry && tx_count == TX_CNT_W'(TX_DEPTH)) |=> !tx_req);
endmodule

// File: rtl/irq_ext_cond.sv
module irq_ext_cond #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ext_en,
    input  logic [N-1:0] ext_in,
    input  logic         clr_ext,
    output logic [N-1:0] ext_pend,
    output logic         ext_req
);
    typedef struct packed {
        logic         primed;
        logic [N-1:0] prev;
        logic [N-1:0] lat;
    } ext_state_t;

    ext_state_t   st_d, st_q;
    logic [N-1:0] edge_hit;

    always_comb begin
        st_d = st_q;
        edge_hit = (ext_in ^ st_q.prev) & ext_en & {N{st_q.primed}};
        st_d.primed = 1'b1;
        st_d.prev   = ext_in;
        st_d.lat    = (clr_ext ? '0 : st_q.lat) | edge_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ext_pend = st_q.lat;
    assign ext_req  = |st_q.lat;

    for (genvar i = 0; i < N; i++) begin : g_src
        assert_masked_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ext_pend[i]) |-> $past(ext_en[i]));
    end

    assert_latch_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_ext && ext_in == st_q.prev) |=> $stable(ext_pend));
endmodule

// File: rtl/serial_irq_gen.sv
module serial_irq_gen
    import irq_src_pkg::*;
#(
    parameter int RX_DEPTH = 4,
    parameter int TX_DEPTH = 4,
    localparam int RX_CNT_W = $clog2(RX_DEPTH + 1),
    localparam int TX_CNT_W = $clog2(TX_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_rx_quad,
    input  logic                cfg_tx_entry,
    input  logic                cfg_par_sc,
    input  logic [EXT_N-1:0]    cfg_ext_en,
    input  logic [RX_CNT_W-1:0] rx_count,
    input  logic                rx_err_ovr,
    input  logic                rx_err_crc,
    input  logic                rx_err_eof,
    input  logic                rx_err_par,
    input  logic                clr_sc,
    input  logic                tx_wr,
    input  logic [TX_CNT_W-1:0] tx_count,
    input  logic [EXT_N-1:0]    ext_in,
    input  logic                clr_ext,
    output logic                rx_req,
    output logic                sc_req,
    output logic [SC_W-1:0]     sc_status,
    output logic                tx_req,
    output logic                ext_req,
    output logic [EXT_N-1:0]    ext_pend
);
    irq_rx_cond #(.RX_DEPTH(RX_DEPTH), .RX_QUAD_LVL(4)) u_rx (
        .clk(clk), .rst_n(rst_n), .cfg_quad(cfg_rx_quad), .cfg_par_sc(cfg_par_sc),
        .rx_count(rx_count), .err_ovr(rx_err_ovr), .err_crc(rx_err_crc),
        .err_eof(rx_err_eof), .err_par(rx_err_par), .clr_sc(clr_sc),
        .rx_req(rx_req), .sc_req(sc_req), .sc_status(sc_status)
    );

    irq_tx_cond #(.TX_DEPTH(TX_DEPTH)) u_tx (
        .clk(clk), .rst_n(rst_n), .cfg_entry(cfg_tx_entry), .tx_wr(tx_wr),
        .tx_count(tx_count), .tx_req(tx_req)
    );

    irq_ext_cond #(.N(EXT_N)) u_ext (
        .clk(clk), .rst_n(rst_n), .ext_en(cfg_ext_en), .ext_in(ext_in),
        .clr_ext(clr_ext), .ext_pend(ext_pend), .ext_req(ext_req)
    );

    assert_reset_quiet_R12: assert property (@(posedge clk)
        !rst_n |-> (!rx_req && !sc_req && !tx_req && !ext_req));
endmodule

// File: tb/test_serial_irq_gen.sv
module test_serial_irq_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_rx_quad = 0, cfg_tx_entry = 0, cfg_par_sc = 0;
    logic [5:0] cfg_ext_en = '0;
    logic [2:0] rx_count = '0, tx_count = '0;
    logic       rx_err_ovr = 0, rx_err_crc = 0, rx_err_eof = 0, rx_err_par = 0;
    logic       clr_sc = 0, tx_wr = 0, clr_ext = 0;
    logic [5:0] ext_in = '0;
    logic       rx_req, sc_req, tx_req, ext_req;
    logic [3:0] sc_status;
    logic [5:0] ext_pend;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    serial_irq_gen i_serial_irq_gen (
        .clk(clk), .rst_n(rst_n), .cfg_rx_quad(cfg_rx_quad), .cfg_tx_entry(cfg_tx_entry),
        .cfg_par_sc(cfg_par_sc), .cfg_ext_en(cfg_ext_en), .rx_count(rx_count),
        .rx_err_ovr(rx_err_ovr), .rx_err_crc(rx_err_crc), .rx_err_eof(rx_err_eof),
        .rx_err_par(rx_err_par), .clr_sc(clr_sc), .tx_wr(tx_wr), .tx_count(tx_count),
        .ext_in(ext_in), .clr_ext(clr_ext), .rx_req(rx_req), .sc_req(sc_req),
        .sc_status(sc_status), .tx_req(tx_req), .ext_req(ext_req), .ext_pend(ext_pend)
    );

    // {quad, entry, rx_count[2:0], tx_count[2:0], exp_rx, exp_tx}
    localparam logic [9:0] VEC [0:7] = '{
        {1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1},
        {1'b0, 1'b0, 3'd1, 3'd1, 1'b1, 1'b0},
        {1'b0, 1'b1, 3'd3, 3'd3, 1'b1, 1'b1},
        {1'b1, 1'b1, 3'd3, 3'd4, 1'b0, 1'b0},
        {1'b1, 1'b0, 3'd4, 3'd2, 1'b1, 1'b0},
        {1'b1, 1'b1, 3'd4, 3'd0, 1'b1, 1'b1},
        {1'b0, 1'b1, 3'd0, 3'd4, 1'b0, 1'b0},
        {1'b1, 1'b0, 3'd1, 3'd0, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rx_count = 3'd1;
        step();
        chk("R12 rx_req", {7'd0, rx_req}, 8'd0);
        chk("R12 sc/tx/ext", {4'd0, sc_status, tx_req, ext_req} , 8'd0);
        chk("R12 ext_pend", {2'd0, ext_pend}, 8'd0);
        rx_count = 3'd0;
        rst_n = 1'b1;

        // R9: no transmit request before first write, both modes
        cfg_tx_entry = 1'b1; tx_count = 3'd0;
        step(); step(); step();
        chk("R9 entry mode unarmed", {7'd0, tx_req}, 8'd0);
        cfg_tx_entry = 1'b0;
        step(); step();
        chk("R9 empty mode unarmed", {7'd0, tx_req}, 8'd0);
        tx_wr = 1'b1; step(); tx_wr = 1'b0;
        tx_count = 3'd1; cfg_tx_entry = 1'b1;
        step();
        chk("R9 armed after write", {7'd0, tx_req}, 8'd1);

        // table: R1 R2 R7 R8
        for (int i = 0; i < 8; i++) begin
            cfg_rx_quad  = VEC[i][9];
            cfg_tx_entry = VEC[i][8];
            rx_count     = VEC[i][7:5];
            tx_count     = VEC[i][4:2];
            step();
            chk(VEC[i][9] ? "R2 rx threshold" : "R1 rx threshold", {7'd0, rx_req}, {7'd0, VEC[i][1]});
            chk(VEC[i][8] ? "R8 tx entry" : "R7 tx empty", {7'd0, tx_req}, {7'd0, VEC[i][0]});
        end

        // special conditions
        cfg_rx_quad = 1'b0; rx_count = 3'd1; cfg_par_sc = 1'b0;
        step();
        rx_err_par = 1'b1; step(); rx_err_par = 1'b0;
        chk("R4 parity masked status", {4'd0, sc_status}, 8'd0);
        chk("R4 parity masked rx_req", {6'd0, sc_req, rx_req}, 8'd1);
        cfg_par_sc = 1'b1;
        rx_err_par = 1'b1; step(); rx_err_par = 1'b0;
        chk("R4 parity enabled", {4'd0, sc_status}, 8'h8);
        chk("R5 precedence", {6'd0, sc_req, rx_req}, 8'd2);
        rx_err_ovr = 1'b1; step(); rx_err_ovr = 1'b0;
        chk("R3 overrun bit0", {4'd0, sc_status}, 8'h9);
        rx_err_crc = 1'b1; rx_err_eof = 1'b1; step();
        rx_err_crc = 1'b0; rx_err_eof = 1'b0;
        chk("R3 crc eof bits", {4'd0, sc_status}, 8'hf);
        step();
        chk("R3 sticky", {4'd0, sc_status}, 8'hf);
        clr_sc = 1'b1; step(); clr_sc = 1'b0;
        chk("R6 cleared", {4'd0, sc_status}, 8'h0);
        chk("R5 rx_req back", {6'd0, sc_req, rx_req}, 8'd1);
        clr_sc = 1'b1; rx_err_eof = 1'b1; step();
        clr_sc = 1'b0; rx_err_eof = 1'b0;
        chk("R6 clear with new error", {4'd0, sc_status}, 8'h4);
        clr_sc = 1'b1; step(); clr_sc = 1'b0;

        // external/status
        cfg_ext_en = 6'b000101;
        ext_in[1] = 1'b1; step();
        chk("R10 disabled source", {1'b0, ext_req, ext_pend}, 8'd0);
        ext_in[0] = 1'b1; step();
        chk("R10 rising edge", {1'b0, ext_req, ext_pend}, 8'h41);
        step();
        chk("R10 held latched", {2'd0, ext_pend}, 8'h01);
        clr_ext = 1'b1; step(); clr_ext = 1'b0;
        chk("R11 cleared", {1'b0, ext_req, ext_pend}, 8'd0);
        step();
        chk("R10 level no event", {2'd0, ext_pend}, 8'd0);
        ext_in[0] = 1'b0; step();
        chk("R10 falling edge", {2'd0, ext_pend}, 8'h01);
        clr_ext = 1'b1; ext_in[2] = 1'b1; step(); clr_ext = 1'b0;
        chk("R11 clear with new edge", {1'b0, ext_req, ext_pend}, 8'h44);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule